// File: doc/BRIEF.md
# Board Control Register Block

A small memory-mapped peripheral that lets software reach a handful of board facilities over a plain 32-bit register bus. The bus has an address, a write strobe, a read strobe, write data and registered read data. The block answers inside a 64 KiB window. The bus address is a 16-bit byte address, and word selection uses bits [15:2].

The block holds five registers:

- A fixed build-identification word.
- A read-only word that reports the processor clock frequency in Hz. This value is chosen at build time through a parameter.
- A read/write LED register whose bits drive output pins. A 1 bit lights its LED.
- A read-only view of the DIP switches. The switch pins are synchronized before software can see them.
- A write-only trigger. Writing one exact key value to it produces a single-cycle board-reset request. Actual reset sequencing is left to the logic that consumes that pulse.

Top module: `brd_ctrl`

## Requirements
- R1: Word 0 (byte offset 0x0) always reads 0x09272011, and a write to it changes nothing.
- R2: Word 1 (offset 0x4) reads the CLK_HZ parameter as an unsigned 32-bit value (default 10,000,000), and a write to it changes nothing.
- R3: A write to word 2 (offset 0x8) stores bits [LED_W-1:0] of the write data. The stored value appears on `led_o` in the cycle after the write edge, with bit n = 1 lighting LED n. A read returns the stored value, zero-extended.
- R4: Word 3 (offset 0xC) reads `sw_i` after a two-flop synchronizer, zero-extended, with 1 = switch on. A read whose clock edge is the second edge after a switch change still returns the old value. A write to word 3 changes nothing.
- R5: Writing exactly 0x0000DEAD to word 4 (offset 0x10) raises `board_rst_req` for exactly the one cycle after the write edge. Any other value written there raises nothing, and word 4 reads as zero.
- R6: Every word index from 5 to 16383 reads as zero, and writes to those words change no register and raise no request.
- R7: Read data is registered. `bus_rdata` holds the selected word in the cycle after a cycle with `bus_rd` high, and holds zero in the cycle after a cycle with `bus_rd` low.
- R8: Address bits [1:0] are ignored, so any byte offset within a word selects that word.
- R9: A synchronous active-high `rst` clears the LED register, `led_o`, `bus_rdata`, `board_rst_req` and the synchronizer flops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 16 | Byte address within the 64 KiB window |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_rd | input | 1 | Read strobe, one access per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| sw_i | input | SW_W | Asynchronous DIP-switch levels |
| led_o | output | LED_W | LED drive, 1 = lit |
| board_rst_req | output | 1 | One-cycle board-reset request |

## Verification
The assertions assume that the bus drives read and write strobes as clean single-cycle levels. They also assume that the address and data are stable around each clock edge and that a read and a write never target the LED word in the same cycle. The bench drives every strobe and data change on the falling edge and issues reads and writes as separate cycles, so it never presents such a collision. It also sweeps the switch pins as whole values between reads, never during one, which keeps the synchronizer checks free of metastable sampling.

// File: rtl/brd_pkg.sv
package brd_pkg;

    localparam int          DATA_W   = 32;
    localparam int          ADDR_W   = 16;
    localparam int          WORD_LSB = 2;
    localparam int          IDX_W    = ADDR_W - WORD_LSB;

    localparam logic [DATA_W-1:0] BUILD_ID = 32'h0927_2011;
    localparam logic [DATA_W-1:0] RST_KEY  = 32'h0000_DEAD;

    typedef enum logic [2:0] {
        SEL_ID   = 3'd0,
        SEL_FREQ = 3'd1,
        SEL_LED  = 3'd2,
        SEL_SW   = 3'd3,
        SEL_RST  = 3'd4,
        SEL_NONE = 3'd7
    } reg_sel_e;

    typedef struct packed {
        logic              rd;
        logic              wr;
        reg_sel_e          sel;
        logic [DATA_W-1:0] wdata;
    } bus_req_t;

    // Maps a word index onto one of the defined registers; all others are holes.
    function automatic reg_sel_e word_to_sel(input logic [IDX_W-1:0] idx);
        reg_sel_e s;
        case (idx)
            IDX_W'(0): s = SEL_ID;
            IDX_W'(1): s = SEL_FREQ;
            IDX_W'(2): s = SEL_LED;
            IDX_W'(3): s = SEL_SW;
            IDX_W'(4): s = SEL_RST;
            default:   s = SEL_NONE;
        endcase
        return s;
    endfunction

    // Zero-extends a narrow field into a bus word.
    function automatic logic [DATA_W-1:0] widen(input logic [DATA_W-1:0] v, input int w);
        logic [DATA_W-1:0] r;
        for (int i = 0; i < DATA_W; i++) begin
            r[i] = (i < w) ? v[i] : 1'b0;
        end
        return r;
    endfunction

endpackage

// File: rtl/brd_decode.sv
module brd_decode
    import brd_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic              rd,
    input  logic [DATA_W-1:0] wdata,
    output bus_req_t          req
);

    logic [IDX_W-1:0] word_idx;

    always_comb begin
        // Bits [1:0] take no part: word-aligned decode only.
        word_idx  = addr[ADDR_W-1:WORD_LSB];
        req.rd    = rd;
        req.wr    = wr;
        req.sel   = word_to_sel(word_idx);
        req.wdata = wdata;
    end

endmodule

// File: rtl/brd_sync.sv
module brd_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    for (genvar b = 0; b < W; b++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) begin
                meta_q[b] <= 1'b0;
                sync_q[b] <= 1'b0;
            end else begin
                meta_q[b] <= d[b];
                sync_q[b] <= meta_q[b];
            end
        end
    end

    assign q = sync_q;

endmodule

// File: rtl/brd_regs.sv
module brd_regs
    import brd_pkg::*;
#(
    parameter int LED_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  bus_req_t         req,
    output logic [LED_W-1:0] led_q,
    output logic             rst_pulse
);

    logic led_we;
    logic key_hit;

    always_comb begin
        led_we  = req.wr && (req.sel == SEL_LED);
        key_hit = req.wr && (req.sel == SEL_RST) && (req.wdata == RST_KEY);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            led_q     <= '0;
            rst_pulse <= 1'b0;
        end else begin
            if (led_we) begin
                led_q <= req.wdata[LED_W-1:0];
            end
            rst_pulse <= key_hit;
        end
    end

    // R3: the LED value only moves on a write aimed at the LED word.
    p_led_hold_r3: assert property (@(posedge clk) disable iff (rst)
        !(req.wr && req.sel == SEL_LED) |=> $stable(led_q));

    // R3: a write to the LED word lands on the outputs one edge later.
    p_led_load_r3: assert property (@(posedge clk) disable iff (rst)
        (req.wr && req.sel == SEL_LED) |=> (led_q == $past(req.wdata[LED_W-1:0])));

endmodule

// File: rtl/brd_ctrl.sv
module brd_ctrl
    import brd_pkg::*;
#(
    parameter int unsigned CLK_HZ = 10_000_000,
    parameter int          LED_W  = 8,
    parameter int          SW_W   = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [15:0]       bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [SW_W-1:0]   sw_i,
    output logic [LED_W-1:0]  led_o,
    output logic              board_rst_req
);

    localparam logic [DATA_W-1:0] FREQ_WORD = DATA_W'(CLK_HZ);

    bus_req_t          req;
    logic [LED_W-1:0]  led_q;
    logic [SW_W-1:0]   sw_sync;
    logic [DATA_W-1:0] rd_mux;
    logic [DATA_W-1:0] rdata_q;
    logic              rst_pulse;

    brd_decode u_decode (
        .addr  (bus_addr),
        .wr    (bus_wr),
        .rd    (bus_rd),
        .wdata (bus_wdata),
        .req   (req)
    );

    brd_sync #(.W(SW_W)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (sw_i),
        .q   (sw_sync)
    );

    brd_regs #(.LED_W(LED_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .req       (req),
        .led_q     (led_q),
        .rst_pulse (rst_pulse)
    );

    always_comb begin
        unique case (req.sel)
            SEL_ID:   rd_mux = BUILD_ID;
            SEL_FREQ: rd_mux = FREQ_WORD;
            SEL_LED:  rd_mux = widen(DATA_W'(led_q), LED_W);
            SEL_SW:   rd_mux = widen(DATA_W'(sw_sync), SW_W);
            default:  rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q <= '0;
        end else begin
            rdata_q <= req.rd ? rd_mux : '0;
        end
    end

    assign bus_rdata     = rdata_q;
    assign led_o         = led_q;
    assign board_rst_req = rst_pulse;

    // R5: a request exists only after a key write to word 4.
    p_req_cause_r5: assert property (@(posedge clk) disable iff (rst)
        board_rst_req |-> $past(bus_wr && bus_addr[15:2] == 14'd4 && bus_wdata == 32'h0000_DEAD));

    // R7: an idle read strobe leaves zero on the data bus.
    p_rdata_idle_r7: assert property (@(posedge clk) disable iff (rst)
        !bus_rd |=> (bus_rdata == 32'd0));

    // R1: the identification word is fixed.
    p_id_read_r1: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr[15:2] == 14'd0) |=> (bus_rdata == 32'h0927_2011));

    // R6: holes in the map read as zero.
    p_hole_zero_r6: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr[15:2] > 14'd4) |=> (bus_rdata == 32'd0));

endmodule

// File: tb/tb_brd_ctrl.sv
module tb_brd_ctrl;

    localparam int unsigned FREQ = 25_000_000;
    localparam int          LW   = 8;
    localparam int          SW   = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [15:0]   bus_addr = '0;
    logic          bus_wr = 1'b0;
    logic          bus_rd = 1'b0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [SW-1:0] sw_i = '0;
    logic [LW-1:0] led_o;
    logic          board_rst_req;

    int checks = 0;
    int errors = 0;
    int pulses = 0;

    brd_ctrl #(.CLK_HZ(FREQ), .LED_W(LW), .SW_W(SW)) dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sw_i(sw_i), .led_o(led_o),
        .board_rst_req(board_rst_req)
    );

    always #4 clk = ~clk;

    always @(posedge clk) if (!rst && board_rst_req) pulses++;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [15:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    function automatic logic [31:0] expect_word(input int idx, input logic [LW-1:0] led, input logic [SW-1:0] s);
        case (idx)
            0: return 32'h0927_2011;
            1: return 32'(FREQ);
            2: return 32'(led);
            3: return 32'(s);
            default: return 32'd0;
        endcase
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] d;
        logic [LW-1:0] led_exp;
        int p0;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R9: reset state
        chk(led_o == '0, "R9 led after reset", 32'(led_o), 0);
        chk(bus_rdata == 0, "R9 rdata after reset", bus_rdata, 0);
        chk(board_rst_req == 0, "R9 req after reset", 32'(board_rst_req), 0);

        // R1 R2 R6 R8: sweep word indices with rotating byte offsets
        led_exp = '0;
        for (int i = 0; i < 64; i++) begin
            rd(16'((i * 4) | (i % 4)), d);
            chk(d == expect_word(i, led_exp, '0), $sformatf("R8 R6 R1 R2 word %0d", i), d, expect_word(i, led_exp, '0));
        end
        rd(16'hFFFF, d);
        chk(d == 0, "R6 top of window", d, 0);

        // R7: idle cycle after a read returns zero
        rd(16'h0000, d);
        @(negedge clk);
        chk(bus_rdata == 0, "R7 idle rdata", bus_rdata, 0);

        // R3: LED pattern sweep
        for (int i = 0; i < 24; i++) begin
            led_exp = LW'(i * 37 + 5);
            wr(16'h0008 | 16'(i % 4), {24'hA5A5A5, led_exp});
            chk(led_o == led_exp, "R3 led pins", 32'(led_o), 32'(led_exp));
            rd(16'h0008, d);
            chk(d == 32'(led_exp), "R3 led readback", d, 32'(led_exp));
        end

        // R1 R2 R4: writes to read-only words change nothing
        wr(16'h0000, 32'h1234_5678);
        wr(16'h0004, 32'h0);
        wr(16'h000C, 32'hFFFF_FFFF);
        rd(16'h0000, d); chk(d == 32'h0927_2011, "R1 id after write", d, 32'h0927_2011);
        rd(16'h0004, d); chk(d == 32'(FREQ), "R2 freq after write", d, 32'(FREQ));
        rd(16'h000C, d); chk(d == 0, "R4 sw after write", d, 0);
        chk(led_o == led_exp, "R4 led untouched", 32'(led_o), 32'(led_exp));

        // R6: writes to holes are ignored
        p0 = pulses;
        for (int i = 5; i < 40; i++) wr(16'(i * 4), 32'h0000_DEAD);
        chk(led_o == led_exp, "R6 led after hole writes", 32'(led_o), 32'(led_exp));
        rd(16'h0050, d); chk(d == 0, "R6 hole read after write", d, 0);
        chk(pulses == p0, "R6 no request", 32'(pulses), 32'(p0));

        // R4: exhaustive switch sweep
        for (int v = 0; v < 256; v++) begin
            @(negedge clk); sw_i = SW'(v);
            @(negedge clk); @(negedge clk);
            rd(16'h000C, d);
            chk(d == 32'(v), "R4 switch value", d, 32'(v));
        end
        // R4: latency, read edge is the second edge after the change
        @(negedge clk); sw_i = 8'h3C;
        rd(16'h000C, d);
        chk(d == 32'h0000_00FF, "R4 sync latency old", d, 32'hFF);
        rd(16'h000C, d);
        chk(d == 32'h0000_003C, "R4 sync latency new", d, 32'h3C);

        // R5: wrong keys raise nothing
        p0 = pulses;
        wr(16'h0010, 32'h0000_DEAE);
        wr(16'h0010, 32'h0001_DEAD);
        wr(16'h0010, 32'hDEAD_0000);
        @(negedge clk);
        chk(pulses == p0, "R5 bad key", 32'(pulses), 32'(p0));
        rd(16'h0010, d); chk(d == 0, "R5 trigger reads zero", d, 0);

        // R5: right key gives one-cycle pulse
        p0 = pulses;
        wr(16'h0012, 32'h0000_DEAD);
        chk(board_rst_req == 1, "R5 pulse high", 32'(board_rst_req), 1);
        @(negedge clk);
        chk(board_rst_req == 0, "R5 pulse low", 32'(board_rst_req), 0);
        repeat (3) @(negedge clk);
        chk(pulses == p0 + 1, "R5 pulse count", 32'(pulses), 32'(p0 + 1));
        chk(led_o == led_exp, "R5 led kept", 32'(led_o), 32'(led_exp));

        // R9: mid-run reset clears LED
        wr(16'h0008, 32'hFF);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); @(negedge clk); rst = 1'b0;
        chk(led_o == 0, "R9 led cleared", 32'(led_o), 0);
        rd(16'h0008, d); chk(d == 0, "R9 led readback cleared", d, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule